// File: doc/BRIEF.md
# Interlaced Field Vertical Timing Generator

This block produces the vertical timing of an interlaced digital video output, one field at a time. A horizontal timing unit supplies a line strobe at each line start and a half-line strobe at each mid-line point. The block counts these strobes as half-lines from the start of each field. From that count it derives which vertical region the output is in: pre-equalization, serration, post-equalization, the rest of vertical blanking, the main (active) lines, or the post-blank lines. It also keeps an even/odd field flag.

Region lengths come from one of two built-in standard presets (525-line and 625-line style) or from programmed inputs. They are latched only at the start of a field. A BT.656-style V flag turns on a programmable number of lines after the main lines end. Odd fields get one extra line of delay, to make up for the unequal main line counts of the two fields. The flag turns off again when the next main region begins.

In slave mode, an external field-start pulse restarts the count at pre-equalization. When the count reaches the last half-line of a field it waits there for that pulse.

Top module: `vt_field_gen`

## Requirements
- R1: During and after a synchronous reset, with no strobe applied, the block is at half-line 0 of an even field: o_region = 0, o_vblank = 1, o_field_odd = 0, o_vflag = 0.
- R2: Each clock cycle with i_line_stb or i_half_stb high advances the half-line position h by exactly one (both high in one cycle count once). o_region encodes h as follows: 0 for pre-equalization (h < P), 1 for serration (h < P+S), 2 for post-equalization (h < P+S+Q), 3 for the remaining blank (h < 2B), 4 for main lines (h < 2B + 2M), and 5 for post-blank after that. M is the main line count of the current field. o_vblank is 1 exactly while h < 2B.
- R3: i_std_sel = 0 selects P=S=Q=6 half-lines, B=21 lines, a field of 525 half-lines, M=240 in even fields and M=241 in odd fields.
- R4: i_std_sel = 1 selects P=S=Q=5 half-lines, B=25 lines, a field of 625 half-lines, and M=287 in both fields.
- R5: i_std_sel = 2 or 3 takes P, S, Q, B, the field length and both M values from the programmed inputs.
- R6: In master mode, a strobe at the last half-line of a field returns h to 0 and toggles o_field_odd.
- R7: The region lengths and the V delay are captured at reset and at each field start only. Input changes made in mid-field take effect in the next field.
- R8: o_vflag rises 2*(D + x) strobes after h enters post-blank. D is the captured i_vdly and x is 1 in an odd field, 0 in an even one. With D = 0 in an even field it rises at the post-blank entry itself. The delay may run past the field boundary.
- R9: o_vflag falls when h enters the main region, and it is never 1 while o_region = 4.
- R10: In slave mode, i_ext_fstart sets h to 0, toggles o_field_odd and captures the configuration. It takes precedence over a strobe in the same cycle.
- R11: In slave mode, strobes at the last half-line of a field leave h unchanged.
- R12: In master mode, i_ext_fstart has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_line_stb | input | 1 | Line-start strobe from horizontal timing |
| i_half_stb | input | 1 | Mid-line strobe from horizontal timing |
| i_std_sel | input | 2 | 0: 525-line preset, 1: 625-line preset, 2/3: programmed |
| i_pre_hl | input | 4 | Programmed pre-equalization length, half-lines |
| i_ser_hl | input | 4 | Programmed serration length, half-lines |
| i_post_hl | input | 4 | Programmed post-equalization length, half-lines |
| i_blank_ln | input | 9 | Programmed vertical blank length, lines |
| i_field_hl | input | 10 | Programmed field length, half-lines |
| i_main_even | input | 9 | Programmed main lines, even field |
| i_main_odd | input | 9 | Programmed main lines, odd field |
| i_vdly | input | 4 | V flag delay D, lines |
| i_slave | input | 1 | 1 selects slave mode |
| i_ext_fstart | input | 1 | External field-start pulse |
| o_region | output | 3 | Vertical region code (R2) |
| o_vblank | output | 1 | Vertical blanking flag |
| o_field_odd | output | 1 | 1 in an odd field |
| o_vflag | output | 1 | BT.656-style V flag |

## Verification
In slave mode, an external field-start pulse and a half-line strobe can land in the same cycle. The design must then restart at half-line 0 and not at half-line 1. The bench drives both in one cycle and checks that the region reads pre-equalization with the field flag toggled. It then applies exactly one more strobe: pre-equalization (position 1) is the correct result, while a design that also counted the coincident strobe would already show serration. The bench also separates the odd-field extra line from the even-field case by checking the V flag at the post-blank half-line where only the even rule would already have raised it.

// File: rtl/vt_pkg.sv
`timescale 1ns/1ps
package vt_pkg;
    parameter int HL_W = 10;  // half-line position width
    parameter int LN_W = 9;   // line count width
    parameter int EQ_W = 4;   // equalization/serration length width
    parameter int VD_W = 4;   // V delay width
    parameter int VC_W = VD_W + 2; // V delay counter width (half-lines)

    typedef enum logic [1:0] {
        STD_525  = 2'd0,
        STD_625  = 2'd1,
        STD_PROG = 2'd2
    } std_e;

    typedef enum logic [2:0] {
        RG_PREEQ  = 3'd0,
        RG_SERR   = 3'd1,
        RG_POSTEQ = 3'd2,
        RG_BLANK  = 3'd3,
        RG_ACTIVE = 3'd4,
        RG_POST   = 3'd5
    } region_e;

    typedef struct packed {
        logic [EQ_W-1:0] pre_hl;
        logic [EQ_W-1:0] ser_hl;
        logic [EQ_W-1:0] post_hl;
        logic [LN_W-1:0] blank_ln;
        logic [HL_W-1:0] field_hl;
        logic [LN_W-1:0] main_even;
        logic [LN_W-1:0] main_odd;
        logic [VD_W-1:0] vdly;
    } vcfg_t;

    // Choose the preset lengths or the programmed ones; V delay always programmed.
    function automatic vcfg_t pick_cfg(input logic [1:0] sel, input vcfg_t prog);
        vcfg_t r;
        r = prog;
        if (sel == STD_525) begin
            r.pre_hl    = EQ_W'(6);
            r.ser_hl    = EQ_W'(6);
            r.post_hl   = EQ_W'(6);
            r.blank_ln  = LN_W'(21);
            r.field_hl  = HL_W'(525);
            r.main_even = LN_W'(240);
            r.main_odd  = LN_W'(241);
        end else if (sel == STD_625) begin
            r.pre_hl    = EQ_W'(5);
            r.ser_hl    = EQ_W'(5);
            r.post_hl   = EQ_W'(5);
            r.blank_ln  = LN_W'(25);
            r.field_hl  = HL_W'(625);
            r.main_even = LN_W'(287);
            r.main_odd  = LN_W'(287);
        end
        return r;
    endfunction
endpackage

// File: rtl/vt_cfg_sel.sv
`timescale 1ns/1ps
module vt_cfg_sel
    import vt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fstart,
    input  logic [1:0]  std_sel,
    input  vcfg_t       prog,
    output vcfg_t       cfg
);
    always_ff @(posedge clk) begin
        if (rst || fstart) begin
            cfg <= pick_cfg(std_sel, prog);
        end
    end

    AST_CFG_HELD_MIDFIELD: assert property (@(posedge clk) disable iff (rst)
        !fstart |=> $stable(cfg)); // R7
endmodule

// File: rtl/vt_line_cnt.sv
`timescale 1ns/1ps
module vt_line_cnt
    import vt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    adv,
    input  logic    slave,
    input  logic    ext_fs,
    input  vcfg_t   cfg,
    output region_e region,
    output logic    vblank,
    output logic    field_odd,
    output logic    fstart,
    output logic    main_begin,
    output logic    main_end
);
    localparam int BW = HL_W + 1;

    logic [HL_W-1:0] h, h_nx;
    logic [LN_W-1:0] mlen;
    logic [BW-1:0]   b_ser, b_post, b_blank, b_main, b_end, h_w, hn_w;
    logic            last, step;

    always_comb begin
        mlen    = field_odd ? cfg.main_odd : cfg.main_even;
        b_ser   = BW'(cfg.pre_hl);
        b_post  = b_ser + BW'(cfg.ser_hl);
        b_blank = b_post + BW'(cfg.post_hl);
        b_main  = BW'({cfg.blank_ln, 1'b0});
        b_end   = b_main + BW'({mlen, 1'b0});
        h_w     = BW'(h);
        last    = (h_w + 1'b1) >= BW'(cfg.field_hl);
        fstart  = slave ? ext_fs : (adv && last);
        step    = fstart || (adv && !last);
        if (fstart)    h_nx = '0;
        else if (step) h_nx = h + 1'b1;
        else           h_nx = h;
        hn_w       = BW'(h_nx);
        main_begin = step && (hn_w == b_main);
        main_end   = step && (hn_w == b_end);

        if (h_w < b_ser)        region = RG_PREEQ;
        else if (h_w < b_post)  region = RG_SERR;
        else if (h_w < b_blank) region = RG_POSTEQ;
        else if (h_w < b_main)  region = RG_BLANK;
        else if (h_w < b_end)   region = RG_ACTIVE;
        else                    region = RG_POST;
        vblank = h_w < b_main;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h         <= '0;
            field_odd <= 1'b0;
        end else begin
            h <= h_nx;
            if (fstart) field_odd <= ~field_odd;
        end
    end

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        adv && !last && !(slave && ext_fs) |=> h == $past(h) + 1'b1); // R2
    AST_MASTER_WRAP: assert property (@(posedge clk) disable iff (rst)
        !slave && adv && last |=> (h == '0) && (field_odd != $past(field_odd))); // R6
    AST_EXT_RESTART: assert property (@(posedge clk) disable iff (rst)
        slave && ext_fs |=> (h == '0) && (field_odd != $past(field_odd))); // R10
    AST_SLAVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        slave && !ext_fs && last |=> $stable(h)); // R11
    AST_MASTER_EXT_IGNORED: assert property (@(posedge clk) disable iff (rst)
        !slave && ext_fs && !adv |=> $stable(h) && $stable(field_odd)); // R12
endmodule

// File: rtl/vt_vflag.sv
`timescale 1ns/1ps
module vt_vflag
    import vt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    input  logic            main_begin,
    input  logic            main_end,
    input  logic            field_odd,
    input  logic [VD_W-1:0] vdly,
    output logic            vflag
);
    logic            vrun;
    logic [VC_W-1:0] vcnt, vtgt;
    logic [VD_W:0]   lines;

    always_comb begin
        lines = {1'b0, vdly} + {{VD_W{1'b0}}, field_odd};
        vflag = vrun && (vcnt >= vtgt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vrun <= 1'b0;
            vcnt <= '0;
            vtgt <= '0;
        end else if (main_begin) begin
            vrun <= 1'b0;
        end else if (main_end) begin
            vrun <= 1'b1;
            vcnt <= '0;
            vtgt <= VC_W'({lines, 1'b0});
        end else if (vrun && adv && (vcnt != {VC_W{1'b1}})) begin
            vcnt <= vcnt + 1'b1;
        end
    end

    AST_ZERO_DELAY_EVEN: assert property (@(posedge clk) disable iff (rst)
        main_end && !main_begin && (vdly == '0) && !field_odd |=> vflag); // R8
    AST_CLEAR_AT_MAIN: assert property (@(posedge clk) disable iff (rst)
        main_begin |=> !vflag); // R9
endmodule

// File: rtl/vt_field_gen.sv
`timescale 1ns/1ps
module vt_field_gen
    import vt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            i_line_stb,
    input  logic            i_half_stb,
    input  logic [1:0]      i_std_sel,
    input  logic [EQ_W-1:0] i_pre_hl,
    input  logic [EQ_W-1:0] i_ser_hl,
    input  logic [EQ_W-1:0] i_post_hl,
    input  logic [LN_W-1:0] i_blank_ln,
    input  logic [HL_W-1:0] i_field_hl,
    input  logic [LN_W-1:0] i_main_even,
    input  logic [LN_W-1:0] i_main_odd,
    input  logic [VD_W-1:0] i_vdly,
    input  logic            i_slave,
    input  logic            i_ext_fstart,
    output logic [2:0]      o_region,
    output logic            o_vblank,
    output logic            o_field_odd,
    output logic            o_vflag
);
    vcfg_t   prog, cfg;
    region_e region;
    logic    adv, fstart, main_begin, main_end;

    always_comb begin
        adv            = i_line_stb | i_half_stb;
        prog.pre_hl    = i_pre_hl;
        prog.ser_hl    = i_ser_hl;
        prog.post_hl   = i_post_hl;
        prog.blank_ln  = i_blank_ln;
        prog.field_hl  = i_field_hl;
        prog.main_even = i_main_even;
        prog.main_odd  = i_main_odd;
        prog.vdly      = i_vdly;
        o_region       = region;
    end

    vt_cfg_sel u_cfg (
        .clk(clk), .rst(rst), .fstart(fstart), .std_sel(i_std_sel),
        .prog(prog), .cfg(cfg)
    );

    vt_line_cnt u_cnt (
        .clk(clk), .rst(rst), .adv(adv), .slave(i_slave), .ext_fs(i_ext_fstart),
        .cfg(cfg), .region(region), .vblank(o_vblank), .field_odd(o_field_odd),
        .fstart(fstart), .main_begin(main_begin), .main_end(main_end)
    );

    vt_vflag u_vf (
        .clk(clk), .rst(rst), .adv(adv), .main_begin(main_begin), .main_end(main_end),
        .field_odd(o_field_odd), .vdly(cfg.vdly), .vflag(o_vflag)
    );

    AST_NO_V_IN_MAIN: assert property (@(posedge clk) disable iff (rst)
        (o_region == RG_ACTIVE) |-> !o_vflag); // R9
    AST_REGION_LEGAL: assert property (@(posedge clk) disable iff (rst)
        o_region <= RG_POST); // R2
endmodule

// File: tb/sim_vt_field_gen.sv
`timescale 1ns/1ps
module sim_vt_field_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_s = 1'b0, half_s = 1'b0;
    logic [1:0] std_sel = 2'd2;
    logic [3:0] pre_hl = 4'd2, ser_hl = 4'd2, post_hl = 4'd2, vdly = 4'd1;
    logic [8:0] blank_ln = 9'd4, main_e = 9'd5, main_o = 9'd4;
    logic [9:0] field_hl = 10'd20;
    logic       slave = 1'b0, ext = 1'b0;
    logic [2:0] region;
    logic       vblank, fodd, vflag;
    int         checks = 0, errors = 0, hb = 0;

    always #2.5 clk = ~clk;

    vt_field_gen u0 (
        .clk(clk), .rst(rst), .i_line_stb(line_s), .i_half_stb(half_s),
        .i_std_sel(std_sel), .i_pre_hl(pre_hl), .i_ser_hl(ser_hl), .i_post_hl(post_hl),
        .i_blank_ln(blank_ln), .i_field_hl(field_hl), .i_main_even(main_e),
        .i_main_odd(main_o), .i_vdly(vdly), .i_slave(slave), .i_ext_fstart(ext),
        .o_region(region), .o_vblank(vblank), .o_field_odd(fodd), .o_vflag(vflag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic strobe(input bit ln, input bit hf);
        @(negedge clk); line_s = ln; half_s = hf;
        @(negedge clk); line_s = 1'b0; half_s = 1'b0;
    endtask

    task automatic go_to(input int t);
        while (hb < t) begin
            strobe(hb % 2 == 1, hb % 2 == 0);
            hb++;
        end
    endtask

    task automatic pulse_ext(input bit with_half);
        @(negedge clk); ext = 1'b1; half_s = with_half;
        @(negedge clk); ext = 1'b0; half_s = 1'b0;
    endtask

    task automatic custom(input int d, input bit sl);
        std_sel = 2'd2; pre_hl = 4'd2; ser_hl = 4'd2; post_hl = 4'd2;
        blank_ln = 9'd4; field_hl = 10'd20; main_e = 9'd5; main_o = 9'd4;
        vdly = 4'(d); slave = sl; ext = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0; hb = 0;
    endtask

    // Expected region for the custom set: P=S=Q=2, B=4, M=5/4
    function automatic int exp_reg(input int h, input bit odd);
        int bend;
        bend = 8 + 2 * (odd ? 4 : 5);
        if (h < 2) return 0;
        if (h < 4) return 1;
        if (h < 6) return 2;
        if (h < 8) return 3;
        if (h < bend) return 4;
        return 5;
    endfunction

    task automatic t_reset();
        custom(1, 0);
        do_reset();
        chk("R1 region", region, 0);
        chk("R1 vblank", vblank, 1);
        chk("R1 field", fodd, 0);
        chk("R1 vflag", vflag, 0);
    endtask

    task automatic t_regions();
        strobe(1'b1, 1'b1); hb = 1;
        chk("R2 dual strobe counts once", region, exp_reg(1, 0));
        for (int h = 2; h < 20; h++) begin
            strobe(h % 2 == 1, h % 2 == 0); hb = h;
            chk("R2/R5 region", region, exp_reg(h, 0));
            chk("R2 vblank", vblank, (h < 8) ? 1 : 0);
            chk("R8 vflag not yet", vflag, 0);
        end
        go_to(20); hb = 0;
        chk("R6 wrap region", region, 0);
        chk("R6 wrap field", fodd, 1);
        chk("R8 even delay 1 reached", vflag, 1);
    endtask

    task automatic t_vflag();
        go_to(7);  chk("R9 held before main", vflag, 1);
        go_to(8);  chk("R9 cleared at main", vflag, 0);
        chk("R9 region main", region, 4);
        go_to(15); chk("R5 odd main length", region, 4);
        go_to(16); chk("R5 odd post", region, 5);
        chk("R8 odd not yet", vflag, 0);
        go_to(18); chk("R8 odd extra line", vflag, 0);
        go_to(19); chk("R8 odd not yet", vflag, 0);
        go_to(20); hb = 0;
        chk("R8 odd delay reached", vflag, 1);
        chk("R6 field back even", fodd, 0);
        custom(0, 0);
        do_reset();
        go_to(17); chk("R8 zero delay before", vflag, 0);
        go_to(18); chk("R8 zero delay even immediate", vflag, 1);
        go_to(20); hb = 0;
        go_to(8);  chk("R9 cleared odd main", vflag, 0);
        go_to(17); chk("R8 odd zero delay one line", vflag, 0);
        go_to(18); chk("R8 odd zero delay reached", vflag, 1);
    endtask

    task automatic t_cfg_mid();
        custom(1, 0);
        do_reset();
        go_to(3);
        blank_ln = 9'd6; field_hl = 10'd24;
        go_to(8);  chk("R7 old blank kept", region, 4);
        go_to(20); hb = 0;
        chk("R7 old field length kept", region, 0);
        chk("R7 field toggled", fodd, 1);
        go_to(8);  chk("R7 new blank used", region, 3);
        go_to(12); chk("R7 new main start", region, 4);
        go_to(20); chk("R7 new field longer", fodd, 1);
        chk("R7 post after new main", region, 5);
        go_to(24); hb = 0;
        chk("R7 new length wrap", region, 0);
        chk("R7 new length field", fodd, 0);
        custom(1, 0);
    endtask

    task automatic t_presets();
        custom(0, 0);
        std_sel = 2'd0;
        do_reset();
        go_to(5);   chk("R3 preeq", region, 0);
        go_to(6);   chk("R3 serration", region, 1);
        go_to(12);  chk("R3 posteq", region, 2);
        go_to(18);  chk("R3 blank", region, 3);
        go_to(41);  chk("R3 blank end", region, 3);
        go_to(42);  chk("R3 main start", region, 4);
        go_to(521); chk("R3 even main end", region, 4);
        go_to(522); chk("R3 even post", region, 5);
        go_to(524); chk("R3 field not wrapped", fodd, 0);
        go_to(525); hb = 0;
        chk("R3 wrap", region, 0);
        chk("R3 odd field", fodd, 1);
        go_to(523); chk("R3 odd main longer", region, 4);
        go_to(524); chk("R3 odd post", region, 5);
        std_sel = 2'd1;
        do_reset();
        go_to(4);   chk("R4 preeq", region, 0);
        go_to(5);   chk("R4 serration", region, 1);
        go_to(10);  chk("R4 posteq", region, 2);
        go_to(15);  chk("R4 blank", region, 3);
        go_to(49);  chk("R4 blank end", region, 3);
        go_to(50);  chk("R4 main start", region, 4);
        go_to(623); chk("R4 main end", region, 4);
        go_to(624); chk("R4 post", region, 5);
        go_to(625); hb = 0;
        chk("R4 wrap", region, 0);
        chk("R4 odd field", fodd, 1);
        custom(1, 0);
    endtask

    task automatic t_slave();
        custom(1, 1);
        do_reset();
        go_to(19); chk("R11 at last", region, 5);
        strobe(1'b0, 1'b1); strobe(1'b1, 1'b0); strobe(1'b0, 1'b1);
        chk("R11 held region", region, 5);
        chk("R11 held field", fodd, 0);
        pulse_ext(1'b1); hb = 0;
        chk("R10 restart region", region, 0);
        chk("R10 field toggled", fodd, 1);
        go_to(1);  chk("R10 ext wins over strobe", region, 0);
        go_to(5);  chk("R10 mid field", region, 2);
        pulse_ext(1'b0); hb = 0;
        chk("R10 mid restart", region, 0);
        chk("R10 mid toggle", fodd, 0);
        custom(1, 0);
        do_reset();
        go_to(5);
        pulse_ext(1'b0);
        chk("R12 ignored region", region, 2);
        chk("R12 ignored field", fodd, 0);
        go_to(6);  chk("R12 count intact", region, 3);
    endtask

    initial begin
        #500000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_regions();
        t_vflag();
        t_cfg_mid();
        t_presets();
        t_slave();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule